// File: doc/BRIEF.md
# Multi-Register Stack Pop Sequencer

This block restores a chosen set of processor registers from a stack frame. A caller presents a select mask and the current stack pointer for one cycle. The block then issues one 32-bit word read per restored register. Each read carries its byte address and the identifier of the register that will receive the word. After the last read has been accepted, the block reports the advanced stack pointer together with a one-cycle done pulse.

The mask has five bits. Four of them pick individual registers. The fifth picks a fixed group of seven registers, which are laid out in a 32-byte frame. The lowest word of that frame is never read. Individually picked registers are stacked directly above the group frame. The order of the reads is fixed by hardware and never depends on how the caller listed the registers. Reads run from the highest offset down to the lowest.

Top module: `pop_seq_top`

## Requirements
- R1: Mask bits 0..3 select the individual registers with identifiers 0, 1, 2 and 3 (D2, D3, A2, A3). These registers are read in the order 0, 1, 2, 3, and any register whose bit is clear is skipped.
- R2: Mask bit 4 selects the group. The group is read as identifiers 4 (D0), 5 (D1), 6 (A0), 7 (A1), 8, 9 and 10 (auxiliary registers), at offsets 28, 24, 20, 16, 12, 8 and 4 in that order. Offset 0 is never read.
- R3: Individual registers are read before the group. When the group is selected they sit at offsets 32 and above. The first read uses the highest offset (frame size minus 4), and each later read is exactly 4 bytes lower.
- R4: Every read address equals the start stack pointer plus the slot offset, taken modulo 2^32, and is 4-byte aligned relative to that pointer.
- R5: The reported stack pointer equals the start value plus 4 times the number of individual registers, plus 32 when bit 4 is set.
- R6: An all-zero mask issues no reads. Done is raised in the cycle right after the start is accepted, with the stack pointer unchanged.
- R7: Done is high for exactly one cycle. That cycle comes right after the cycle in which the last read was accepted, no read is requested while done is high, and the block is idle in the next cycle.
- R8: A start while busy is high is ignored, and the running sequence and its result are unchanged.
- R9: While a read is requested and not acknowledged, the request, address and identifier stay unchanged.
- R10: After reset the block is idle, with busy, read request and done all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start a pop (taken only when idle) |
| mask_i | input | 5 | Register select mask |
| sp_i | input | 32 | Stack pointer at start |
| busy_o | output | 1 | Sequence in progress |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 32 | Read byte address |
| rd_dst_o | output | 4 | Destination register identifier |
| rd_ack_i | input | 1 | Read accepted this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 32 | Updated stack pointer, valid with done |

## Verification
The checker enforces, on every cycle, the properties that hold at any time: a stalled request holds steady, offsets are aligned and fall by one word per accepted beat, done lasts a single cycle with no request beside it, and group beats never touch offset 0 or carry an individual identifier. A start arriving while busy must also leave the captured base unchanged. Only the bench scenarios can show the exact order of identifiers for a given mask, the absolute addresses, the final stack pointer, and the cycle in which done arrives. The bench predicts these from the frame layout for many masks, both with and without stalls.

// File: rtl/pop_seq_pkg.sv
package pop_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IND  = 2'd1,
    ST_GRP  = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;

  // number of set bits in a word
  function automatic int unsigned ones(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += v[i] ? 1 : 0;
    return n;
  endfunction

  // byte size of the popped frame
  function automatic int unsigned frame_size(input int unsigned n_ind,
                                             input logic grp,
                                             input int unsigned grp_n,
                                             input int unsigned word_b);
    return n_ind * word_b + (grp ? (grp_n + 1) * word_b : 0);
  endfunction

endpackage

// File: rtl/pop_frame_calc.sv
module pop_frame_calc #(
  parameter int IND_N  = 4,
  parameter int GRP_N  = 7,
  parameter int WORD_B = 4,
  parameter int OFF_W  = 7
) (
  input  logic [IND_N:0]   mask_i,
  output logic [OFF_W-1:0] frame_o,
  output logic             has_ind_o,
  output logic             has_grp_o
);
  import pop_seq_pkg::*;

  int unsigned n_ind;

  always_comb begin
    n_ind     = ones(32'(mask_i[IND_N-1:0]));
    frame_o   = OFF_W'(frame_size(n_ind, mask_i[IND_N], GRP_N, WORD_B));
    has_ind_o = |mask_i[IND_N-1:0];
    has_grp_o = mask_i[IND_N];
  end

endmodule

// File: rtl/pop_slot_pick.sv
module pop_slot_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  rem_i,
  output logic [N-1:0]  oh_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] seen;

  generate
    for (genvar g = 0; g < N; g++) begin : g_pri
      if (g == 0) begin : g_first
        assign seen[g] = 1'b0;
      end else begin : g_rest
        assign seen[g] = seen[g-1] | rem_i[g-1];
      end
      assign oh_o[g] = rem_i[g] & ~seen[g];
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (oh_o[i]) idx_o = IW'(i);
  end

endmodule

// File: rtl/pop_seq_top.sv
module pop_seq_top #(
  parameter int AW     = 32,
  parameter int IND_N  = 4,
  parameter int GRP_N  = 7,
  parameter int WORD_B = 4,
  parameter int ID_W   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [IND_N:0]  mask_i,
  input  logic [AW-1:0]   sp_i,
  output logic            busy_o,
  output logic            rd_req_o,
  output logic [AW-1:0]   rd_addr_o,
  output logic [ID_W-1:0] rd_dst_o,
  input  logic            rd_ack_i,
  output logic            done_o,
  output logic [AW-1:0]   sp_o
);
  import pop_seq_pkg::*;

  localparam int OFF_W = $clog2((IND_N + GRP_N + 1) * WORD_B) + 1;
  localparam int IDX_W = (IND_N > 1) ? $clog2(IND_N) : 1;
  localparam int GI_W  = (GRP_N > 1) ? $clog2(GRP_N) : 1;

  seq_state_e       state;
  logic [IND_N-1:0] rem;
  logic [AW-1:0]    base;
  logic [AW-1:0]    sp_new;
  logic [OFF_W-1:0] off;
  logic [GI_W-1:0]  gidx;
  logic             grp_en;

  logic [OFF_W-1:0] frame;
  logic             has_ind, has_grp;
  logic [IND_N-1:0] pick_oh;
  logic [IDX_W-1:0] pick_idx;
  logic [IND_N-1:0] rem_next;

  // named events for the checker
  logic             beat_w, ind_beat_w, grp_beat_w;
  logic [OFF_W-1:0] off_w;
  logic [AW-1:0]    base_w;

  pop_frame_calc #(.IND_N(IND_N), .GRP_N(GRP_N), .WORD_B(WORD_B), .OFF_W(OFF_W)) u_calc (
    .mask_i(mask_i), .frame_o(frame), .has_ind_o(has_ind), .has_grp_o(has_grp)
  );

  pop_slot_pick #(.N(IND_N), .IW(IDX_W)) u_pick (
    .rem_i(rem), .oh_o(pick_oh), .idx_o(pick_idx)
  );

  assign rem_next   = rem & ~pick_oh;
  assign rd_req_o   = (state == ST_IND) || (state == ST_GRP);
  assign beat_w     = rd_req_o && rd_ack_i;
  assign ind_beat_w = beat_w && (state == ST_IND);
  assign grp_beat_w = beat_w && (state == ST_GRP);
  assign off_w      = off;
  assign base_w     = base;

  assign rd_addr_o = base + AW'(off);
  assign rd_dst_o  = (state == ST_GRP) ? (ID_W'(IND_N) + ID_W'(gidx)) : ID_W'(pick_idx);
  assign busy_o    = (state != ST_IDLE);
  assign done_o    = (state == ST_FIN);
  assign sp_o      = sp_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      rem    <= '0;
      base   <= '0;
      sp_new <= '0;
      off    <= '0;
      gidx   <= '0;
      grp_en <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          base   <= sp_i;
          sp_new <= sp_i + AW'(frame);
          rem    <= mask_i[IND_N-1:0];
          grp_en <= mask_i[IND_N];
          off    <= frame - OFF_W'(WORD_B);
          gidx   <= '0;
          state  <= has_ind ? ST_IND : (has_grp ? ST_GRP : ST_FIN);
        end
        ST_IND: if (rd_ack_i) begin
          rem <= rem_next;
          off <= off - OFF_W'(WORD_B);
          if (rem_next == '0) state <= grp_en ? ST_GRP : ST_FIN;
        end
        ST_GRP: if (rd_ack_i) begin
          off  <= off - OFF_W'(WORD_B);
          gidx <= gidx + 1'b1;
          if (gidx == GI_W'(GRP_N - 1)) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pop_seq_chk.sv
module pop_seq_chk #(
  parameter int AW     = 32,
  parameter int OFF_W  = 7,
  parameter int ID_W   = 4,
  parameter int IND_N  = 4,
  parameter int WORD_B = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req_o,
  input logic            rd_ack_i,
  input logic [AW-1:0]   rd_addr_o,
  input logic [ID_W-1:0] rd_dst_o,
  input logic            done_o,
  input logic            busy_o,
  input logic            start_i,
  input logic [AW-1:0]   base_w,
  input logic [OFF_W-1:0] off_w,
  input logic            beat_w,
  input logic            ind_beat_w,
  input logic            grp_beat_w
);

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o) && $stable(rd_dst_o));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  a_r7_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_req_o);

  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(base_w));

  a_r4_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (off_w % OFF_W'(WORD_B)) == '0);

  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    beat_w |=> !rd_req_o || (off_w == $past(off_w) - OFF_W'(WORD_B)));

  a_r2_group_slot: assert property (@(posedge clk) disable iff (!rst_n)
    grp_beat_w |-> off_w != '0 && rd_dst_o >= ID_W'(IND_N));

  a_r1_single_id: assert property (@(posedge clk) disable iff (!rst_n)
    ind_beat_w |-> rd_dst_o < ID_W'(IND_N));

endmodule

bind pop_seq_top pop_seq_chk #(
  .AW(AW), .OFF_W(OFF_W), .ID_W(ID_W), .IND_N(IND_N), .WORD_B(WORD_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i),
  .rd_addr_o(rd_addr_o), .rd_dst_o(rd_dst_o), .done_o(done_o), .busy_o(busy_o),
  .start_i(start_i), .base_w(base_w), .off_w(off_w), .beat_w(beat_w),
  .ind_beat_w(ind_beat_w), .grp_beat_w(grp_beat_w)
);

// File: tb/sim_pop_seq_top.sv
module sim_pop_seq_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  mask_i = '0;
  logic [31:0] sp_i = '0;
  logic        busy_o, rd_req_o, done_o;
  logic [31:0] rd_addr_o, sp_o;
  logic [3:0]  rd_dst_o;
  logic        rd_ack_i = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;

  pop_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i), .sp_i(sp_i),
    .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_dst_o(rd_dst_o),
    .rd_ack_i(rd_ack_i), .done_o(done_o), .sp_o(sp_o)
  );

  always #10 clk = ~clk;

  // {mask, sp, stall}
  localparam logic [37:0] VECS [0:9] = '{
    {5'h01, 32'h0000_1000, 1'b0},
    {5'h0F, 32'h0000_2000, 1'b0},
    {5'h10, 32'h0000_3000, 1'b0},
    {5'h11, 32'h0000_4000, 1'b1},
    {5'h1F, 32'h0000_5000, 1'b0},
    {5'h0A, 32'h0000_6004, 1'b1},
    {5'h14, 32'h0000_7000, 1'b0},
    {5'h00, 32'h0000_8000, 1'b0},
    {5'h1D, 32'hFFFF_FFF0, 1'b1},
    {5'h08, 32'h0000_0008, 1'b0}
  };

  logic [31:0] exp_addr [0:15];
  logic [3:0]  exp_dst  [0:15];
  int          exp_n;
  logic [31:0] exp_sp;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // layout: singles (fixed id order) over a 32-byte group frame, descending
  task automatic build_exp(input logic [4:0] m, input logic [31:0] sp);
    int n_ind;
    int j;
    n_ind = 0;
    for (int i = 0; i < 4; i++) if (m[i]) n_ind++;
    exp_n = 0;
    j = 0;
    for (int i = 0; i < 4; i++) begin
      if (m[i]) begin
        exp_dst[exp_n]  = 4'(i);
        exp_addr[exp_n] = sp + 32'((m[4] ? 32 : 0) + 4 * (n_ind - 1 - j));
        exp_n++;
        j++;
      end
    end
    if (m[4]) begin
      for (int k = 0; k < 7; k++) begin
        exp_dst[exp_n]  = 4'(4 + k);
        exp_addr[exp_n] = sp + 32'(28 - 4 * k);
        exp_n++;
      end
    end
    exp_sp = sp + 32'(4 * n_ind + (m[4] ? 32 : 0));
  endtask

  task automatic run_vec(input logic [4:0] m, input logic [31:0] sp, input bit stall, input bit poke);
    int beat;
    int cyc;
    bit fin;
    build_exp(m, sp);
    @(negedge clk);
    start_i = 1'b1; mask_i = m; sp_i = sp;
    @(negedge clk);
    start_i = 1'b0; mask_i = '0; sp_i = '0;
    beat = 0; cyc = 0; fin = 0;
    while (!fin && cyc < 200) begin
      rd_ack_i = 1'b0;
      if (poke && cyc == 1) begin
        start_i = 1'b1; mask_i = 5'h1F; sp_i = 32'h0;
      end else begin
        start_i = 1'b0; mask_i = '0; sp_i = '0;
      end
      if (done_o) begin
        fin = 1;
        check(sp_o == exp_sp, "R5 final sp", sp_o, exp_sp);
        check(beat == exp_n, "R7 done after last read", 32'(beat), 32'(exp_n));
        check(!rd_req_o, "R7 no req with done", {31'b0, rd_req_o}, 32'd0);
        if (exp_n == 0) begin
          check(cyc == 0, "R6 empty done next cycle", 32'(cyc), 32'd0);
          check(sp_o == sp, "R6 sp unchanged", sp_o, sp);
        end
      end else if (rd_req_o) begin
        if (beat < exp_n) begin
          check(rd_dst_o == exp_dst[beat], "R1/R2 dst order", {28'b0, rd_dst_o}, {28'b0, exp_dst[beat]});
          check(rd_addr_o == exp_addr[beat], "R3/R4 read address", rd_addr_o, exp_addr[beat]);
        end else begin
          check(0, "R7 extra read", 32'(beat), 32'(exp_n));
        end
        if (!stall || cyc[0]) begin
          rd_ack_i = 1'b1;
          beat++;
        end
      end else begin
        check(0, "R7 gap without req or done", 32'(beat), 32'(exp_n));
        fin = 1;
      end
      @(negedge clk);
      cyc++;
    end
    rd_ack_i = 1'b0; start_i = 1'b0;
    if (!fin) check(0, "R7 timeout", 32'(cyc), 32'd200);
    check(!done_o && !busy_o, "R7 single-cycle done", {30'b0, done_o, busy_o}, 32'd0);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !rd_req_o && !done_o, "R10 reset state", {29'b0, busy_o, rd_req_o, done_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !rd_req_o && !done_o, "R10 idle after reset", {29'b0, busy_o, rd_req_o, done_o}, 32'd0);

    for (int v = 0; v < 10; v++) begin
      run_vec(VECS[v][37:33], VECS[v][32:1], VECS[v][0], 1'b0);
    end

    // R8: start during a running pop changes nothing
    run_vec(5'h05, 32'h0000_A000, 1'b1, 1'b1);

    // R9: stalled request holds still
    @(negedge clk);
    start_i = 1'b1; mask_i = 5'h02; sp_i = 32'h0000_B000;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_req_o && rd_addr_o == 32'h0000_B000 && rd_dst_o == 4'd1, "R9 hold while stalled",
          rd_addr_o, 32'h0000_B000);
    // reset mid-sequence returns to idle
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy_o && !rd_req_o && !done_o, "R10 reset mid-run", {29'b0, busy_o, rd_req_o, done_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 again after reset
    run_vec(5'h00, 32'h0000_C000, 1'b0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule